// File: doc/BRIEF.md
# Serial Addressed DAC Register Loader

This block is the programming port of a bank of converter setting registers. A host clocks a 24-bit frame into it one bit per rising edge of the serial clock. The frame carries an 8-bit address first and a 16-bit data word after it, and within each field the least significant bit comes first. When the last bit is in, the whole frame is copied into a central holding latch. On the falling edge that follows, the data field is written into the one setting register that the address selects.

Two kinds of register share the same frame length. Wide registers keep a 13-bit value and narrow registers keep a 6-bit value. Data bits the selected kind does not use are discarded, as are addresses outside the map.

A synchronous enable gates everything. While it is low the frame counter is held at zero, the shift register keeps its contents, and no latch or register can be loaded. The oldest bit of the shift register is driven on a serial output, so that several loaders can be chained on one data line.

Top module: `dacld_loader`

## Requirements
- R1: `sdi` is sampled on the rising edge of `clk` while `en` is high. Frame bit k, for k = 0 to 23, is the k-th sampled bit. Bits 0..7 form the address, LSB first, and bits 8..23 form data bits 0..15, LSB first.
- R2: A frame whose address is 0..NUM_WIDE-1 (0..9 by default) writes data bits [15:3] into that wide register. Wide register i appears on `wide_q[13*i +: 13]`.
- R3: A frame whose address is NARROW_BASE..NARROW_BASE+NUM_NARROW-1 (16..19 by default) writes data bits [8:3] into narrow register (address − NARROW_BASE). Narrow register j appears on `narrow_q[6*j +: 6]`.
- R4: Register outputs do not change on the 24th rising edge. They change on the falling edge that follows it.
- R5: While `en` is low, the bit counter is cleared, the shift register and `sdo` hold their values, and no register is written. A frame started after `en` rises is aligned from bit 0, even if an earlier frame was cut short.
- R6: If `en` is low at the falling edge after the 24th rising edge, no register is written.
- R7: A frame whose address matches neither range leaves every register unchanged. At most one register is written per frame.
- R8: `sdo` equals the bit that was sampled 24 enabled rising edges earlier. The bits of the previous frame therefore leave in the order they entered.
- R9: While `rst` is high on clock edges, the shift register, counter, central latch and all registers are cleared, so `sdo` and every register output read zero.
- R10: Frames sent back to back with `en` held high are each committed. The counter wraps from 23 to 0 with no idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock: shift on the rising edge, commit on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synchronous enable for shifting and loading |
| sdi | input | 1 | Serial data in, LSB first |
| sdo | output | 1 | Serial data out for chaining |
| wide_q | output | NUM_WIDE*13 | Wide register contents, register i at [13*i +: 13] |
| narrow_q | output | NUM_NARROW*6 | Narrow register contents, register j at [6*j +: 6] |

## Verification
The embedded assertions check the following on every cycle:
- the counter stays in range and clears while disabled;
- the shift register and central latch hold when they should;
- at most one register is selected;
- a selected register takes the write data on its falling edge, and an unselected bank stays stable.

Other behaviours can only be shown by the bench's scenarios:
- LSB-first bit placement;
- field extraction for each register kind;
- rejection of unmapped addresses;
- the enable dropped between the last rising edge and its falling edge;
- realignment after a truncated frame;
- the 24-clock delay on the serial output.

The bench compares all of these against its own model of the register file.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    localparam int FRAME_BITS = 24;
    localparam int ADDR_BITS  = 8;
    localparam int DATA_BITS  = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    localparam int WIDE_W     = 13;
    localparam int WIDE_LSB   = 3;
    localparam int NARROW_W   = 6;
    localparam int NARROW_LSB = 3;

    // Address sits in the low bits because it is shifted in first.
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic [ADDR_BITS-1:0] addr;
    } frame_t;

endpackage

// File: rtl/dacld_shifter.sv
module dacld_shifter
    import dacld_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   sdi,
    output logic   sdo,
    output frame_t latch_q,
    output logic   frame_done
);

    logic [FRAME_BITS-1:0] sh_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] sh_next;

    assign sh_next = {sdi, sh_q[FRAME_BITS-1:1]};
    assign sdo     = sh_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            latch_q    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!en) begin
                cnt_q <= '0;
            end else begin
                sh_q <= sh_next;
                if (cnt_q == LAST_BIT) begin
                    cnt_q      <= '0;
                    latch_q    <= frame_t'(sh_next);
                    frame_done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assert_cnt_range_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_BIT);

    assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt_q == '0);

    assert_shift_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sh_q));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(en && cnt_q == LAST_BIT) |=> $stable(latch_q));

    assert_done_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> cnt_q == '0);

endmodule

// File: rtl/dacld_decode.sv
module dacld_decode
    import dacld_pkg::*;
#(
    parameter int NUM_WIDE    = 10,
    parameter int NUM_NARROW  = 4,
    parameter int NARROW_BASE = 16
) (
    input  logic [ADDR_BITS-1:0] addr,
    input  logic                 commit,
    output logic [NUM_WIDE-1:0]  wide_sel,
    output logic [NUM_NARROW-1:0] narrow_sel
);

    for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
        assign wide_sel[i] = commit && (addr == ADDR_BITS'(i));
    end

    for (genvar j = 0; j < NUM_NARROW; j++) begin : g_narrow
        assign narrow_sel[j] = commit && (addr == ADDR_BITS'(NARROW_BASE + j));
    end

    always_comb begin
        assert_sel_onehot_R7: assert ($onehot0({wide_sel, narrow_sel}));
    end

endmodule

// File: rtl/dacld_regbank.sv
module dacld_regbank #(
    parameter int COUNT = 4,
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COUNT-1:0]   sel,
    input  logic [WIDTH-1:0]   wdata,
    output logic [COUNT*WIDTH-1:0] q
);

    // Written on the falling edge so the commit trails the last shift edge.
    for (genvar i = 0; i < COUNT; i++) begin : g_reg
        always_ff @(negedge clk) begin
            if (rst) begin
                q[i*WIDTH +: WIDTH] <= '0;
            end else if (sel[i]) begin
                q[i*WIDTH +: WIDTH] <= wdata;
            end
        end

        assert_write_R4: assert property (@(negedge clk) disable iff (rst)
            sel[i] |=> q[i*WIDTH +: WIDTH] == $past(wdata));
    end

    assert_hold_unsel_R7: assert property (@(negedge clk) disable iff (rst)
        !(|sel) |=> $stable(q));

endmodule

// File: rtl/dacld_loader.sv
module dacld_loader
    import dacld_pkg::*;
#(
    parameter int NUM_WIDE    = 10,
    parameter int NUM_NARROW  = 4,
    parameter int NARROW_BASE = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       sdi,
    output logic                       sdo,
    output logic [NUM_WIDE*WIDE_W-1:0] wide_q,
    output logic [NUM_NARROW*NARROW_W-1:0] narrow_q
);

    frame_t                latch_q;
    logic                  frame_done;
    logic                  commit;
    logic [NUM_WIDE-1:0]   wide_sel;
    logic [NUM_NARROW-1:0] narrow_sel;
    logic [WIDE_W-1:0]     wide_wdata;
    logic [NARROW_W-1:0]   narrow_wdata;
    logic [2:0]            unused_data_bits;

    dacld_shifter u_shifter (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .sdi        (sdi),
        .sdo        (sdo),
        .latch_q    (latch_q),
        .frame_done (frame_done)
    );

    // Enable is checked again at the falling edge that commits.
    assign commit = frame_done && en;

    dacld_decode #(
        .NUM_WIDE    (NUM_WIDE),
        .NUM_NARROW  (NUM_NARROW),
        .NARROW_BASE (NARROW_BASE)
    ) u_decode (
        .addr       (latch_q.addr),
        .commit     (commit),
        .wide_sel   (wide_sel),
        .narrow_sel (narrow_sel)
    );

    assign wide_wdata       = latch_q.data[WIDE_LSB +: WIDE_W];
    assign narrow_wdata     = latch_q.data[NARROW_LSB +: NARROW_W];
    assign unused_data_bits = latch_q.data[2:0];

    dacld_regbank #(
        .COUNT (NUM_WIDE),
        .WIDTH (WIDE_W)
    ) u_wide_bank (
        .clk   (clk),
        .rst   (rst),
        .sel   (wide_sel),
        .wdata (wide_wdata),
        .q     (wide_q)
    );

    dacld_regbank #(
        .COUNT (NUM_NARROW),
        .WIDTH (NARROW_W)
    ) u_narrow_bank (
        .clk   (clk),
        .rst   (rst),
        .sel   (narrow_sel),
        .wdata (narrow_wdata),
        .q     (narrow_q)
    );

endmodule

// File: tb/tb_dacld_loader.sv
module tb_dacld_loader;

    localparam int NW = 10;
    localparam int NN = 4;
    localparam int NB = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic [NW*13-1:0] wide_q;
    logic [NN*6-1:0]  narrow_q;

    dacld_loader #(.NUM_WIDE(NW), .NUM_NARROW(NN), .NARROW_BASE(NB)) dut (
        .clk(clk), .rst(rst), .en(en), .sdi(sdi),
        .sdo(sdo), .wide_q(wide_q), .narrow_q(narrow_q)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cycles = 0;

    logic [12:0] wide_exp [NW];
    logic [5:0]  narrow_exp [NN];
    logic [23:0] sh_model;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 150000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NW; i++) chk(req, 32'(wide_q[i*13 +: 13]), 32'(wide_exp[i]));
        for (int j = 0; j < NN; j++) chk(req, 32'(narrow_q[j*6 +: 6]), 32'(narrow_exp[j]));
    endtask

    function automatic void model_write(input logic [7:0] a, input logic [15:0] d);
        if (int'(a) < NW) wide_exp[a] = d[15:3];
        else if (int'(a) >= NB && int'(a) < NB + NN) narrow_exp[int'(a) - NB] = d[8:3];
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < NW; i++) wide_exp[i] = '0;
        for (int j = 0; j < NN; j++) narrow_exp[j] = '0;
        sh_model = '0;
    endfunction

    // Starts and ends at falling edge + 1 ns.
    task automatic send_frame(input logic [7:0] a, input logic [15:0] d,
                              input bit drop_en, input string req);
        logic [23:0] fr;
        fr = {d, a};
        for (int k = 0; k < 24; k++) begin
            en  = 1'b1;
            sdi = fr[k];
            chk("R8", 32'(sdo), 32'(sh_model[0]));
            @(posedge clk);
            sh_model = {fr[k], sh_model[23:1]};
            #1;
        end
        if (drop_en) en = 1'b0;
        check_regs("R4");   // nothing moves on the 24th rising edge
        @(negedge clk);
        #1;
        if (!drop_en) model_write(a, d);
        check_regs(req);
    endtask

    task automatic send_bits(input int n);
        for (int k = 0; k < n; k++) begin
            logic b;
            b   = 1'($urandom);
            en  = 1'b1;
            sdi = b;
            @(posedge clk);
            sh_model = {b, sh_model[23:1]};
            #1;
        end
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            en  = 1'b0;
            sdi = 1'($urandom);
            @(posedge clk);
            #1;
            chk("R5", 32'(sdo), 32'(sh_model[0]));
            @(negedge clk);
            #1;
        end
        check_regs("R5");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model_clear();
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        // R9: reset state
        chk("R9", 32'(sdo), 32'd0);
        check_regs("R9");

        // R1/R2: directed LSB-first placement, wide registers at both ends
        send_frame(8'd0, 16'hFFF8, 1'b0, "R2");
        send_frame(8'd9, 16'h8009, 1'b0, "R1");
        send_frame(8'd5, 16'hA5A5, 1'b0, "R2");
        // R3: narrow registers, bits outside [8:3] set to check that they are dropped
        send_frame(8'd16, 16'hFE07, 1'b0, "R3");
        send_frame(8'd19, 16'h0148, 1'b0, "R3");
        // R7: unmapped addresses including just past each range and upper address bits
        send_frame(8'd10, 16'hFFFF, 1'b0, "R7");
        send_frame(8'd20, 16'hFFFF, 1'b0, "R7");
        send_frame(8'h80, 16'hFFFF, 1'b0, "R7");
        send_frame(8'h85, 16'h1234, 1'b0, "R7");
        // R6: enable dropped after the last rising edge, before the commit edge
        send_frame(8'd3, 16'hBEEF, 1'b1, "R6");
        send_frame(8'd17, 16'h01F8, 1'b1, "R6");
        // R5: idle with toggling data, then a truncated frame followed by a full frame
        idle(6);
        send_bits(11);
        idle(2);
        send_frame(8'd7, 16'h3C3C, 1'b0, "R5");
        // R10: back-to-back frames with enable held
        for (int n = 0; n < 6; n++)
            send_frame(8'(n), 16'(16'h1111 * (n + 1)), 1'b0, "R10");

        // Constrained random mix
        for (int n = 0; n < 60; n++) begin
            logic [7:0] a;
            int pick;
            pick = int'($urandom_range(0, 9));
            if (pick < 5)      a = 8'($urandom_range(0, NW - 1));
            else if (pick < 8) a = 8'($urandom_range(NB, NB + NN - 1));
            else               a = 8'($urandom_range(NW, 255));
            if (int'(a) >= NB && int'(a) < NB + NN && pick >= 8) a = 8'd200;
            send_frame(a, 16'($urandom), ($urandom_range(0, 7) == 0),
                       (int'(a) < NW) ? "R2" : ((int'(a) >= NB && int'(a) < NB + NN) ? "R3" : "R7"));
            if ($urandom_range(0, 5) == 0) idle(int'($urandom_range(1, 3)));
        end

        // R9: reset mid-run
        en  = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        model_clear();
        chk("R9", 32'(sdo), 32'd0);
        check_regs("R9");
        send_frame(8'd18, 16'h0038, 1'b0, "R3");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule